// File: doc/BRIEF.md
# Endpoint Base Address Register Decoder

This block holds the base address registers of one endpoint function together with the two enable bits of its command register. Configuration software writes and reads the registers through a dword-indexed port. To learn a region's size, software writes all ones to a slot and reads it back. The storage keeps only the address bits at or above the region size, so the readback is the size mask. The type and prefetch attribute bits are constants set by parameters.

A second port takes host accesses: a 64-bit address and a flag that says whether the access targets I/O space or memory space. One cycle later the block returns a one-hot vector that names the matching slot, or raises a miss flag. A slot may be an empty slot, a 32-bit memory BAR, the lower half of a 64-bit memory BAR, or an I/O BAR. When a slot is a 64-bit BAR, the slot after it carries the upper 32 address bits and must be declared empty in the parameters. The block accepts a request on every cycle and cannot stall, and no ready signal exists on either side. A result stays on the outputs for exactly the one cycle after its request, and the consumer must take it in that cycle.

Top module: `bar_decoder`

## Requirements
- R1: Dword index 1 holds the command enables. Bit 0 enables I/O decoding and bit 1 enables memory decoding. All other bits of that dword read as zero.
- R2: BAR slot i sits at dword index 4+i. A write replaces the slot's writable bits, and a read returns them merged with the slot's fixed bits. Read data appears on cfg_rdata with cfg_rvalid high in the cycle after cfg_rd.
- R3: Bit 0 reads 1 for an I/O BAR and 0 for a memory BAR. Memory bits 2:1 read 00 for a 32-bit BAR and 10 for a 64-bit BAR. Memory bit 3 is the prefetch parameter. I/O bit 1 reads 0.
- R4: Address bits below the region size read as zero, whatever was written. Writing all ones therefore returns the size mask. Memory regions are at least 128 bytes and I/O regions at least 4 bytes.
- R5: For a 64-bit memory BAR, the next slot stores address bits 63:32. It is fully writable when the region is smaller than 4 GiB, and it takes part in the address compare.
- R6: Empty slots and all dword indices other than 1 and 4 to 9 read as zero, and writes to them are ignored.
- R7: Reset clears every base field and both enables, so no access hits until software enables decoding.
- R8: A memory access can hit only memory BARs, and only while the memory enable is set. An I/O access can hit only I/O BARs, and only while the I/O enable is set.
- R9: An access hits a slot when its address lies in [base, base+size). 32-bit memory BARs and I/O BARs match only when address bits 63:32 are zero.
- R10: res_valid follows req_valid by one cycle. When valid, res_hit is one-hot at the slot index (the lower slot for a 64-bit BAR), and the lowest index wins when regions overlap. res_miss is high exactly when nothing hits. Both are zero when res_valid is low.
- R11: A base or enable written at one clock edge applies to a request presented in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_rd | input | 1 | Configuration read strobe |
| cfg_idx | input | 6 | Dword index of the configuration access |
| cfg_wdata | input | 32 | Write data |
| cfg_rvalid | output | 1 | Read data valid, one cycle after cfg_rd |
| cfg_rdata | output | 32 | Read data |
| req_valid | input | 1 | Host access present |
| req_is_io | input | 1 | 1 = I/O space access, 0 = memory space access |
| req_addr | input | 64 | Host access address |
| res_valid | output | 1 | Decode result valid |
| res_hit | output | NSLOT | One-hot index of the matching slot |
| res_miss | output | 1 | No slot matched the access |

## Verification
A corrupted base register shows up in two places. The size-probe readback of that slot is wrong in the cycle after its read strobe. A lookup at the region edges also returns a miss or the wrong slot one cycle after the request. A command enable stuck in the wrong state flips every hit of its space type into a miss, or every miss into a hit, from the next request on. Overlapping regions expose a faulty priority order in res_hit, and a request issued right after a write exposes any extra delay before a new base or enable takes effect.

// File: rtl/bar_pkg.sv
package bar_pkg;

  typedef enum logic [1:0] {
    KIND_NONE  = 2'd0,
    KIND_MEM32 = 2'd1,
    KIND_MEM64 = 2'd2,
    KIND_IO    = 2'd3
  } bar_kind_e;

  localparam int ADDR_W = 64;
  localparam int DATA_W = 32;
  localparam int IDX_W  = 6;

  // Region size exponent after applying the minimum for each space type.
  function automatic int eff_log2(input logic [1:0] kind, input int req);
    int r;
    r = req;
    if (kind == KIND_IO) begin
      if (r < 2) r = 2;
    end else if (kind == KIND_MEM32 || kind == KIND_MEM64) begin
      if (r < 7) r = 7;
    end else begin
      r = 0;
    end
    if (r > 63) r = 63;
    return r;
  endfunction

  // Address bits at or above the region size.
  function automatic logic [63:0] region_mask(input int lg);
    logic [63:0] one;
    one = 64'd1;
    return ~((one << lg) - one);
  endfunction

  function automatic logic [31:0] slot_wmask(input logic [1:0] kind, input int lg,
                                             input bit is_upper);
    logic [63:0] m;
    m = region_mask(lg);
    if (is_upper) return m[63:32];
    case (kind)
      KIND_MEM32, KIND_MEM64: return m[31:0] & 32'hFFFF_FFF0;
      KIND_IO:                return m[31:0] & 32'hFFFF_FFFC;
      default:                return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] slot_fixed(input logic [1:0] kind, input bit pref,
                                             input bit is_upper);
    if (is_upper) return 32'h0;
    case (kind)
      KIND_MEM32: return {28'd0, pref, 2'b00, 1'b0};
      KIND_MEM64: return {28'd0, pref, 2'b10, 1'b0};
      KIND_IO:    return 32'h0000_0001;
      default:    return 32'h0;
    endcase
  endfunction

endpackage

// File: rtl/bar_slot.sv
module bar_slot
  import bar_pkg::*;
#(
  parameter logic [1:0] KIND     = KIND_NONE,
  parameter int         LOG2     = 0,
  parameter bit         PREF     = 1'b0,
  parameter bit         IS_UPPER = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic [31:0] store
);

  localparam int          LG    = eff_log2(KIND, LOG2);
  localparam logic [31:0] WMASK = slot_wmask(KIND, LG, IS_UPPER);
  localparam logic [31:0] FIXED = slot_fixed(KIND, PREF, IS_UPPER);

  always_ff @(posedge clk) begin
    if (!rst_n)     store <= '0;
    else if (wr_en) store <= wdata & WMASK;
  end

  assign rdata = store | FIXED;

  // R2: a slot's contents change only through a configuration write to it.
  assert_slot_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(store));

endmodule

// File: rtl/bar_match.sv
module bar_match
  import bar_pkg::*;
#(
  parameter int                   NSLOT     = 6,
  parameter logic [2*NSLOT-1:0]   SLOT_KIND = '0,
  parameter logic [6*NSLOT-1:0]   SLOT_LOG2 = '0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NSLOT*32-1:0]   store_all,
  input  logic                  mem_en,
  input  logic                  io_en,
  input  logic                  req_valid,
  input  logic                  req_is_io,
  input  logic [ADDR_W-1:0]     req_addr,
  output logic                  res_valid,
  output logic [NSLOT-1:0]      res_hit,
  output logic                  res_miss
);

  logic [NSLOT*32+31:0] store_ext;
  logic [NSLOT-1:0]     raw_hit;
  logic [NSLOT-1:0]     sel;

  assign store_ext = {32'd0, store_all};

  for (genvar i = 0; i < NSLOT; i++) begin : g_cmp
    localparam logic [1:0]  K      = SLOT_KIND[2*i +: 2];
    localparam int          LG     = eff_log2(K, int'(SLOT_LOG2[6*i +: 6]));
    localparam logic [63:0] MASK   = region_mask(LG);
    localparam bit          IS_IO  = (K == KIND_IO);
    localparam bit          IS_MEM = (K == KIND_MEM32) || (K == KIND_MEM64);
    localparam bit          WIDE   = (K == KIND_MEM64) && (i < NSLOT - 1);

    logic [63:0] base;
    logic        en_ok;

    if (WIDE) begin : g_wide
      assign base = {store_ext[(i+1)*32 +: 32], store_ext[i*32 +: 32]};
    end else begin : g_narrow
      assign base = {32'd0, store_ext[i*32 +: 32]};
    end

    if (IS_IO) begin : g_io
      assign en_ok = io_en && req_is_io;
      assert_io_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        res_hit[i] |-> ($past(io_en) && $past(req_is_io)));
    end else if (IS_MEM) begin : g_mem
      assign en_ok = mem_en && !req_is_io;
      assert_mem_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        res_hit[i] |-> ($past(mem_en) && !$past(req_is_io)));
    end else begin : g_none
      assign en_ok = 1'b0;
      assert_empty_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !res_hit[i]);
    end

    assign raw_hit[i] = en_ok && (((req_addr ^ base) & MASK) == 64'd0);
  end

  // Lowest index wins on overlap.
  always_comb begin
    sel = '0;
    for (int i = 0; i < NSLOT; i++) begin
      if (raw_hit[i] && (sel == '0)) sel[i] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_hit   <= '0;
      res_miss  <= 1'b0;
    end else begin
      res_valid <= req_valid;
      res_hit   <= req_valid ? sel : '0;
      res_miss  <= req_valid && (sel == '0);
    end
  end

  assert_hit_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(res_hit));
  assert_result_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> res_valid);
  assert_result_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> (res_hit == '0 && !res_miss));
  assert_miss_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_miss == (res_hit == '0)));

endmodule

// File: rtl/bar_decoder.sv
module bar_decoder
  import bar_pkg::*;
#(
  parameter int                 NSLOT     = 6,
  // Two bits per slot: 0 empty, 1 mem32, 2 mem64 (lower half), 3 I/O.
  parameter logic [2*NSLOT-1:0] SLOT_KIND = 12'b01_00_11_01_00_10,
  // Six bits per slot: log2 of the region size in bytes.
  parameter logic [6*NSLOT-1:0] SLOT_LOG2 = {6'd20, 6'd0, 6'd5, 6'd7, 6'd0, 6'd12},
  parameter logic [NSLOT-1:0]   SLOT_PREF = 6'b000001
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_wr,
  input  logic                cfg_rd,
  input  logic [IDX_W-1:0]    cfg_idx,
  input  logic [DATA_W-1:0]   cfg_wdata,
  output logic                cfg_rvalid,
  output logic [DATA_W-1:0]   cfg_rdata,
  input  logic                req_valid,
  input  logic                req_is_io,
  input  logic [ADDR_W-1:0]   req_addr,
  output logic                res_valid,
  output logic [NSLOT-1:0]    res_hit,
  output logic                res_miss
);

  localparam logic [IDX_W-1:0]   CMD_IDX   = IDX_W'(1);
  localparam int                 BAR_IDX0  = 4;
  localparam logic [2*NSLOT+1:0] KIND_PREV = {SLOT_KIND, 2'b00};
  localparam logic [6*NSLOT+5:0] LOG2_PREV = {SLOT_LOG2, 6'd0};

  logic [1:0]            cmd_q;   // [0] I/O enable, [1] memory enable
  logic [31:0]           slot_rd [NSLOT];
  logic [NSLOT*32-1:0]   slot_store;
  logic [31:0]           rd_word;

  always_ff @(posedge clk) begin
    if (!rst_n)                          cmd_q <= 2'b00;
    else if (cfg_wr && cfg_idx == CMD_IDX) cmd_q <= cfg_wdata[1:0];
  end

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    localparam logic [1:0] PK = KIND_PREV[2*i +: 2];
    localparam bit         UP = (PK == KIND_MEM64);
    localparam logic [1:0] K  = UP ? KIND_MEM64 : SLOT_KIND[2*i +: 2];
    localparam int         LG = UP ? int'(LOG2_PREV[6*i +: 6]) : int'(SLOT_LOG2[6*i +: 6]);

    logic wr_hit;
    assign wr_hit = cfg_wr && (cfg_idx == IDX_W'(BAR_IDX0 + i));

    bar_slot #(
      .KIND     (K),
      .LOG2     (LG),
      .PREF     (SLOT_PREF[i]),
      .IS_UPPER (UP)
    ) u_slot (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (wr_hit),
      .wdata (cfg_wdata),
      .rdata (slot_rd[i]),
      .store (slot_store[i*32 +: 32])
    );
  end

  always_comb begin
    rd_word = '0;
    if (cfg_idx == CMD_IDX) rd_word = {30'd0, cmd_q};
    for (int i = 0; i < NSLOT; i++) begin
      if (cfg_idx == IDX_W'(BAR_IDX0 + i)) rd_word = slot_rd[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_rvalid <= 1'b0;
      cfg_rdata  <= '0;
    end else begin
      cfg_rvalid <= cfg_rd;
      if (cfg_rd) cfg_rdata <= rd_word;
    end
  end

  bar_match #(
    .NSLOT     (NSLOT),
    .SLOT_KIND (SLOT_KIND),
    .SLOT_LOG2 (SLOT_LOG2)
  ) u_match (
    .clk       (clk),
    .rst_n     (rst_n),
    .store_all (slot_store),
    .mem_en    (cmd_q[1]),
    .io_en     (cmd_q[0]),
    .req_valid (req_valid),
    .req_is_io (req_is_io),
    .req_addr  (req_addr),
    .res_valid (res_valid),
    .res_hit   (res_hit),
    .res_miss  (res_miss)
  );

  assert_read_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rd |=> cfg_rvalid);
  assert_read_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rd |=> !cfg_rvalid);
  assert_cmd_reserved_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rvalid && $past(cfg_idx) == CMD_IDX) |-> (cfg_rdata[31:2] == 30'd0));

endmodule

// File: tb/bar_decoder_tb.sv
module bar_decoder_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic        cfg_rd = 1'b0;
  logic [5:0]  cfg_idx = '0;
  logic [31:0] cfg_wdata = '0;
  logic        cfg_rvalid;
  logic [31:0] cfg_rdata;
  logic        req_valid = 1'b0;
  logic        req_is_io = 1'b0;
  logic [63:0] req_addr = '0;
  logic        res_valid;
  logic [5:0]  res_hit;
  logic        res_miss;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  bar_decoder u_dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
    .cfg_rvalid(cfg_rvalid), .cfg_rdata(cfg_rdata),
    .req_valid(req_valid), .req_is_io(req_is_io), .req_addr(req_addr),
    .res_valid(res_valid), .res_hit(res_hit), .res_miss(res_miss)
  );

  // Size-probe table: write all ones to the index, expect this readback.
  localparam int NVEC = 9;
  localparam logic [5:0]  VEC_IDX [NVEC] = '{6'd1, 6'd4, 6'd5, 6'd6, 6'd7, 6'd8, 6'd9, 6'd2, 6'd0};
  localparam logic [31:0] VEC_EXP [NVEC] = '{32'h0000_0003, 32'hFFFF_F00C, 32'hFFFF_FFFF,
                                             32'hFFFF_FF80, 32'hFFFF_FFE1, 32'h0000_0000,
                                             32'hFFF0_0000, 32'h0000_0000, 32'h0000_0000};
  localparam string       VEC_REQ [NVEC] = '{"R1", "R3 R4", "R5", "R4", "R3 R4", "R6",
                                             "R4", "R6", "R6"};

  task automatic check32(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [5:0] idx, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_idx = idx; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic cfg_read(input logic [5:0] idx, input logic [31:0] exp, input string req);
    @(negedge clk);
    cfg_rd = 1'b1; cfg_idx = idx;
    @(negedge clk);
    cfg_rd = 1'b0;
    check32({31'd0, cfg_rvalid}, 32'd1, req);
    check32(cfg_rdata, exp, req);
  endtask

  task automatic check_res(input logic [5:0] exp_hit, input string req);
    check32({24'd0, res_valid, res_miss, res_hit},
            {24'd0, 1'b1, (exp_hit == 6'd0), exp_hit}, req);
  endtask

  task automatic lookup(input logic [63:0] a, input logic io, input logic [5:0] exp_hit,
                        input string req);
    @(negedge clk);
    req_valid = 1'b1; req_is_io = io; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    check_res(exp_hit, req);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(4 * 50000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // Reset state (R7, R3)
    cfg_read(6'd1, 32'h0, "R7 command cleared");
    cfg_read(6'd4, 32'h0000_000C, "R3 R7 mem64 prefetch attributes");
    cfg_read(6'd7, 32'h0000_0001, "R3 R7 io attribute");
    cfg_read(6'd6, 32'h0, "R7 mem32 base cleared");
    lookup(64'h0, 1'b0, 6'b0, "R7 no decode after reset");
    @(negedge clk);
    check32({29'd0, res_valid, res_miss, 1'b0}, 32'd0, "R10 idle result");

    // Size probing table
    for (int v = 0; v < NVEC; v++) begin
      cfg_write(VEC_IDX[v], 32'hFFFF_FFFF);
      cfg_read(VEC_IDX[v], VEC_EXP[v], VEC_REQ[v]);
    end

    // Program bases with decoding disabled
    cfg_write(6'd1, 32'h0);
    cfg_write(6'd4, 32'h8000_0000);
    cfg_write(6'd5, 32'h0000_0001);
    cfg_write(6'd6, 32'h0001_0055);
    cfg_write(6'd7, 32'h0000_1003);
    cfg_write(6'd9, 32'h0020_0000);
    cfg_read(6'd6, 32'h0001_0000, "R4 low bits dropped");
    cfg_read(6'd7, 32'h0000_1001, "R3 R4 io low bits");
    cfg_read(6'd5, 32'h0000_0001, "R5 upper dword");
    lookup(64'h1_8000_0010, 1'b0, 6'b0, "R8 memory disabled");

    // Memory decoding only
    cfg_write(6'd1, 32'h0000_0002);
    lookup(64'h1_8000_0000, 1'b0, 6'b000001, "R9 mem64 base");
    lookup(64'h1_8000_0FFF, 1'b0, 6'b000001, "R9 mem64 last byte");
    lookup(64'h1_8000_1000, 1'b0, 6'b0,      "R9 mem64 past end");
    lookup(64'h0_8000_0000, 1'b0, 6'b0,      "R5 upper bits compared");
    lookup(64'h0_0001_007F, 1'b0, 6'b000100, "R9 mem32 last byte");
    lookup(64'h0_0001_0080, 1'b0, 6'b0,      "R9 mem32 past end");
    lookup(64'h0_002F_FFFF, 1'b0, 6'b100000, "R9 mem32 1MB region");
    lookup(64'h1_0001_0000, 1'b0, 6'b0,      "R9 mem32 high bits");
    lookup(64'h0_0000_1000, 1'b1, 6'b0,      "R8 io disabled");

    // I/O decoding only
    cfg_write(6'd1, 32'h0000_0001);
    lookup(64'h0_0000_101F, 1'b1, 6'b001000, "R8 R9 io hit");
    lookup(64'h0_0000_1020, 1'b1, 6'b0,      "R9 io past end");
    lookup(64'h0_0001_0000, 1'b0, 6'b0,      "R8 memory off under io enable");
    lookup(64'h0_0001_0000, 1'b1, 6'b0,      "R8 io access to memory region");

    // Overlap and priority
    cfg_write(6'd1, 32'h0000_0003);
    cfg_write(6'd9, 32'h0001_0000);
    cfg_read(6'd9, 32'h0, "R4 alignment to region size");
    lookup(64'h0_0001_0000, 1'b0, 6'b000100, "R10 lowest index wins");
    lookup(64'h0_0002_0000, 1'b0, 6'b100000, "R10 overlapped region alone");

    // Write followed at once by a request
    @(negedge clk);
    cfg_wr = 1'b1; cfg_idx = 6'd6; cfg_wdata = 32'h0003_0000;
    @(negedge clk);
    cfg_wr = 1'b0;
    req_valid = 1'b1; req_is_io = 1'b0; req_addr = 64'h0_0003_0040;
    @(negedge clk);
    req_valid = 1'b0;
    check_res(6'b000100, "R11 new base next cycle");

    // Enable cleared and request in the next cycle
    @(negedge clk);
    cfg_wr = 1'b1; cfg_idx = 6'd1; cfg_wdata = 32'h0;
    @(negedge clk);
    cfg_wr = 1'b0;
    req_valid = 1'b1; req_is_io = 1'b0; req_addr = 64'h0_0003_0040;
    @(negedge clk);
    req_valid = 1'b0;
    check_res(6'b0, "R11 R8 enable cleared next cycle");

    // Reset in mid-run
    cfg_write(6'd1, 32'h0000_0003);
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    cfg_read(6'd1, 32'h0, "R7 command cleared by reset");
    cfg_read(6'd6, 32'h0, "R7 base cleared by reset");
    lookup(64'h0_0003_0040, 1'b0, 6'b0, "R7 no hit after reset");

    finish_run();
  end

endmodule